// File: doc/BRIEF.md
# Endian-Selectable Word Memory Port

This block is a word-wide access port onto a small byte-addressed storage array. A requester presents a 32-bit load or store together with a byte address and a per-request byte-order choice. The port moves the word to or from four consecutive byte locations that begin at the given address. The order is most-significant byte first or least-significant byte first, according to that choice.

Every word access must fall on a 4-byte boundary. A request at any other address is refused. The response for a refused request carries a fault flag and zero data, and the storage does not change. Each accepted request gets exactly one response, one clock later. The storage size is a parameter, and addresses wrap modulo that size.

Top module: `endian_word_port`

## Requirements
- R1: After reset, rsp_valid, rsp_fault and rsp_rdata are 0, and every storage byte holds 0x00.
- R2: For a read with big_endian=1, the byte at the base address appears in rsp_rdata[31:24] and the byte at base+3 appears in rsp_rdata[7:0]. Bytes 1A C8 B2 46 read as 0x1AC8B246.
- R3: For a read with big_endian=0, the byte at the base address appears in rsp_rdata[7:0] and the byte at base+3 appears in rsp_rdata[31:24]. Bytes 1A C8 B2 46 read as 0x46B2C81A.
- R4: A write with big_endian=1 stores req_wdata[31:24] at the base address, down to req_wdata[7:0] at base+3. All four bytes change on the same clock edge, and a read in the next cycle sees them.
- R5: A write with big_endian=0 stores req_wdata[7:0] at the base address, up to req_wdata[31:24] at base+3.
- R6: big_endian is taken with each request. A word written in one order and read back in the other returns with its bytes reversed.
- R7: Each cycle with req_valid=1 produces rsp_valid=1 in the next cycle, for that cycle only. A cycle with req_valid=0 produces rsp_valid=0 in the next cycle.
- R8: A request whose req_addr[1:0] is not 00 gives rsp_fault=1 with rsp_rdata=0 in its response cycle and leaves all storage bytes unchanged. An aligned request gives rsp_fault=0.
- R9: Storage is indexed by req_addr modulo DEPTH_BYTES (default 64), so addresses A and A+DEPTH_BYTES reach the same bytes.
- R10: The response to an aligned write has rsp_rdata=0 and rsp_fault=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store word, 0 = load word |
| req_addr | input | ADDR_W (16) | Byte address of the word's base |
| req_wdata | input | 32 | Store data |
| big_endian | input | 1 | Byte order for this request: 1 = base byte is most significant |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_fault | output | 1 | Request was misaligned and not performed |
| rsp_rdata | output | 32 | Load data; zero for stores and faults |

## Verification
The bench writes the example bytes 1A C8 B2 46 and reads them back in both orders. If the lane mapping were reversed or mixed, the wrong word or a partly swapped word would come back. It issues misaligned stores at every non-zero low-address value and then reads the surrounding aligned words. A design that performed misaligned stores or returned stale data on a fault would show corrupted neighbours or non-zero fault data. It also reaches the same bytes through addresses one storage depth apart, to catch wrong wrap-around indexing. Finally, it compares a long random mix of orders and alignments against a byte-level model.

// File: rtl/endmem_pkg.sv
package endmem_pkg;
    localparam int BYTE_W = 8;
    localparam int LANES  = 4;
    localparam int WORD_W = BYTE_W * LANES;

    typedef logic [BYTE_W-1:0]             byte_t;
    typedef logic [LANES-1:0][BYTE_W-1:0]  lane_vec_t;

    typedef struct packed {
        logic              valid;
        logic              fault;
        logic [WORD_W-1:0] rdata;
    } rsp_t;
endpackage

// File: rtl/endmem_addr_decode.sv
module endmem_addr_decode #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 2,
    parameter int IDX_W  = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              misaligned,
    output logic [IDX_W-1:0]  word_idx
);
    // low offset bits select a byte inside a word; any non-zero value is off-boundary
    assign misaligned = |addr[OFF_W-1:0];
    // upper bits beyond the storage depth are discarded, giving modulo wrap
    assign word_idx   = addr[OFF_W +: IDX_W];
endmodule

// File: rtl/endmem_lane_order.sv
module endmem_lane_order
    import endmem_pkg::*;
#(
    parameter int N_LANES = 4
) (
    input  logic                          big_endian,
    input  logic [N_LANES*BYTE_W-1:0]     word_in,
    output logic [N_LANES-1:0][BYTE_W-1:0] lanes_out,
    input  logic [N_LANES-1:0][BYTE_W-1:0] lanes_in,
    output logic [N_LANES*BYTE_W-1:0]     word_out
);
    // lane k is the byte at address base+k
    for (genvar k = 0; k < N_LANES; k++) begin : g_lane
        localparam int MSB_FIRST = N_LANES - 1 - k;
        assign lanes_out[k] = big_endian ? word_in[MSB_FIRST*BYTE_W +: BYTE_W]
                                         : word_in[k*BYTE_W +: BYTE_W];
        assign word_out[k*BYTE_W +: BYTE_W] = big_endian ? lanes_in[MSB_FIRST]
                                                         : lanes_in[k];
    end
endmodule

// File: rtl/endmem_byte_store.sv
module endmem_byte_store
    import endmem_pkg::*;
#(
    parameter int DEPTH_BYTES = 64,
    parameter int N_LANES     = 4,
    localparam int WORDS      = DEPTH_BYTES / N_LANES,
    localparam int IDX_W      = $clog2(WORDS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               idx,
    input  logic [N_LANES-1:0][BYTE_W-1:0] wr_lanes,
    output logic [N_LANES-1:0][BYTE_W-1:0] rd_lanes
);
    logic [N_LANES-1:0][BYTE_W-1:0] mem_q [WORDS];
    logic [N_LANES-1:0][BYTE_W-1:0] mem_d [WORDS];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[idx] = wr_lanes;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) begin
                mem_q[w] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_lanes = mem_q[idx];
endmodule

// File: rtl/endian_word_port.sv
module endian_word_port
    import endmem_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DEPTH_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic              big_endian,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [31:0]       rsp_rdata
);
    localparam int OFF_W = $clog2(LANES);
    localparam int WORDS = DEPTH_BYTES / LANES;
    localparam int IDX_W = $clog2(WORDS);

    logic                          misaligned;
    logic [IDX_W-1:0]              word_idx;
    logic [LANES-1:0][BYTE_W-1:0]  wr_lanes;
    logic [LANES-1:0][BYTE_W-1:0]  rd_lanes;
    logic [WORD_W-1:0]             rd_word;
    logic                          wr_en;
    rsp_t                          rsp_d, rsp_q;

    endmem_addr_decode #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .IDX_W  (IDX_W)
    ) u_decode (
        .addr       (req_addr),
        .misaligned (misaligned),
        .word_idx   (word_idx)
    );

    endmem_lane_order #(
        .N_LANES (LANES)
    ) u_lanes (
        .big_endian (big_endian),
        .word_in    (req_wdata),
        .lanes_out  (wr_lanes),
        .lanes_in   (rd_lanes),
        .word_out   (rd_word)
    );

    endmem_byte_store #(
        .DEPTH_BYTES (DEPTH_BYTES),
        .N_LANES     (LANES)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .idx      (word_idx),
        .wr_lanes (wr_lanes),
        .rd_lanes (rd_lanes)
    );

    always_comb begin
        wr_en       = req_valid && req_write && !misaligned;
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        rsp_d.fault = req_valid && misaligned;
        if (req_valid && !req_write && !misaligned) begin
            rsp_d.rdata = rd_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_fault = rsp_q.fault;
    assign rsp_rdata = rsp_q.rdata;
endmodule

// File: rtl/endmem_checker.sv
module endmem_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [31:0]       req_wdata,
    input logic              big_endian,
    input logic              rsp_valid,
    input logic              rsp_fault,
    input logic [31:0]       rsp_rdata
);
    // R7: a request is answered in the following cycle
    a_r7_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R7: no request, no response
    a_r7_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R8: off-boundary address is reported
    a_r8_fault_on_misalign: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[1:0] != 2'b00) |=> (rsp_fault && rsp_valid));

    // R8: aligned address is never reported
    a_r8_no_fault_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[1:0] == 2'b00) |=> !rsp_fault);

    // R8: fault carries zero data
    a_r8_fault_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_rdata == 32'h0));

    // R10: store responses carry zero data
    a_r10_write_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_rdata == 32'h0));
endmodule

bind endian_word_port endmem_checker #(.ADDR_W(ADDR_W)) u_endmem_checker (.*);

// File: tb/endian_word_port_test.sv
`timescale 1ns/1ps
module endian_word_port_test;
    localparam int ADDR_W = 16;
    localparam int DEPTH  = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic              big_endian = 1'b0;
    logic              rsp_valid;
    logic              rsp_fault;
    logic [31:0]       rsp_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] model [DEPTH];

    always #2.5 clk = ~clk;

    endian_word_port #(.ADDR_W(ADDR_W), .DEPTH_BYTES(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .big_endian(big_endian),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int base_of(input logic [ADDR_W-1:0] a);
        return (int'(a) % DEPTH) & ~3;
    endfunction

    function automatic logic [31:0] model_read(input logic [ADDR_W-1:0] a, input logic be);
        int b = base_of(a);
        if (be) return {model[b], model[b+1], model[b+2], model[b+3]};
        return {model[b+3], model[b+2], model[b+1], model[b]};
    endfunction

    task automatic model_write(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic be);
        int b = base_of(a);
        for (int k = 0; k < 4; k++) begin
            model[b+k] = be ? d[(3-k)*8 +: 8] : d[k*8 +: 8];
        end
    endtask

    // one request, response checked in the cycle after acceptance
    task automatic access(input string req, input logic wr, input logic [ADDR_W-1:0] a,
                          input logic [31:0] d, input logic be);
        logic mis;
        logic [31:0] exp;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; big_endian = be;
        mis = (a[1:0] != 2'b00);
        exp = (!wr && !mis) ? model_read(a, be) : 32'h0;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_wdata = $urandom; big_endian = $urandom;
        chk("R7", "rsp_valid", {31'b0, rsp_valid}, 32'h1);
        chk(mis ? "R8" : req, "rsp_fault", {31'b0, rsp_fault}, {31'b0, mis});
        chk(mis ? "R8" : (wr ? "R10" : req), "rsp_rdata", rsp_rdata, exp);
        if (wr && !mis) model_write(a, d, be);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state of outputs and storage
        chk("R1", "rsp_valid", {31'b0, rsp_valid}, 32'h0);
        chk("R1", "rsp_fault", {31'b0, rsp_fault}, 32'h0);
        chk("R1", "rsp_rdata", rsp_rdata, 32'h0);
        for (int w = 0; w < DEPTH/4; w++) access("R1", 1'b0, ADDR_W'(w*4), 32'h0, w[0]);

        // R4 then R2/R3/R6: the example word in both orders
        access("R4", 1'b1, 16'd8, 32'h1AC8B246, 1'b1);
        access("R2", 1'b0, 16'd8, 32'h0, 1'b1);
        chk("R2", "example big", model_read(16'd8, 1'b1), 32'h1AC8B246);
        access("R3", 1'b0, 16'd8, 32'h0, 1'b0);
        chk("R6", "example swapped", model_read(16'd8, 1'b0), 32'h46B2C81A);

        // R5: little-endian store
        access("R5", 1'b1, 16'd12, 32'h11223344, 1'b0);
        access("R5", 1'b0, 16'd12, 32'h0, 1'b0);
        access("R6", 1'b0, 16'd12, 32'h0, 1'b1);

        // R7: idle cycle after a response
        @(negedge clk);
        chk("R7", "idle rsp_valid", {31'b0, rsp_valid}, 32'h0);

        // R8: misaligned stores at each offset leave storage intact
        for (int o = 1; o < 4; o++) access("R8", 1'b1, ADDR_W'(8 + o), 32'hDEADBEEF, o[0]);
        access("R8", 1'b0, 16'd14, 32'h0, 1'b1);
        access("R8", 1'b0, 16'd4, 32'h0, 1'b1);
        access("R8", 1'b0, 16'd8, 32'h0, 1'b1);
        access("R8", 1'b0, 16'd12, 32'h0, 1'b1);

        // R9: wrap modulo depth
        access("R9", 1'b0, 16'd8 + 16'(DEPTH), 32'h0, 1'b1);
        access("R9", 1'b1, 16'd16 + 16'(3*DEPTH), 32'hCAFEF00D, 1'b0);
        access("R9", 1'b0, 16'd16, 32'h0, 1'b0);
        access("R9", 1'b0, 16'hFFFC, 32'h0, 1'b1);

        // random mix against the byte model
        for (int n = 0; n < 400; n++) begin
            logic [ADDR_W-1:0] a = ADDR_W'($urandom);
            if (($urandom % 4) != 0) a[1:0] = 2'b00;
            access("R6", 1'($urandom), a, $urandom, 1'($urandom));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule